// File: doc/BRIEF.md
# Splittable Event Performance Counter Unit

This block counts hardware events for performance analysis. It has four physical counters of 32 bits. Each physical counter can be split at run time into two independent 16-bit halves, so software sees up to eight logical counters. Every logical counter has its own control word. The control word picks one of 64 event lines, can invert that line, chooses between counting rising edges and counting high cycles, and enables the counter.

A global control word gates all counting. It holds a master enable, a freeze, a privilege-mode filter that is compared against the `priv_mode` input, a choice between wrap and saturate on overflow, and the per-counter split bits. An overflow of any logical counter sets a sticky status bit. The interrupt output is raised when a set status bit is also enabled in the interrupt mask. Reading the status register clears the bits it returns.

All state is reached through a plain single-cycle register port. A write is committed on the clock edge where `reg_wr_en` is high. Read data is combinational from `reg_addr`. The register port is control traffic, so it has no valid/ready handshake and can never stall.

Top module: `perfmon_unit`

## Requirements
- R1: After reset every register reads zero, no counter counts and `irq` is low.
- R2: The address map uses word addresses. Address 0 is global control: bit 31 enables, bit 30 saturates, bits 24:21 are the split bits, bit 20 freezes and bits 19:18 hold the privilege filter. Address 1 is status (read-only). Address 2 is the interrupt mask, with bits 31:24 in the status layout. Address 8+n is the control word of logical counter n. Address 16+n is the value of logical counter n. Unimplemented bits read 0.
- R3: With control bit 23 clear, a counter adds one for each rising edge of its qualified input. The input is selected by control bits 31:26.
- R4: With control bit 23 set, a counter adds one on every clock edge at which its qualified input is high.
- R5: Control bit 24 inverts the selected event line before edge or level detection.
- R6: Global bit (24−p) splits physical counter p. Logical counter p then uses the low 16 bits and logical counter p+4 uses the high 16 bits, and the two count independently. In 32-bit mode, logical p reads and writes all 32 bits, logical p+4 reads 0, and writes to p+4 are ignored.
- R7: Without saturation, a counter at its maximum (0xFFFF or 0xFFFFFFFF) that increments wraps to 0 and sets status bit (31−n).
- R8: With saturation, a counter stops at its maximum. It sets its status bit on the increment that reaches the maximum, and never sets it again while it holds there.
- R9: A status read returns the sticky bits and clears exactly those bits. `irq` is high while any status bit has its mask bit set.
- R10: While freeze is set or enable is clear, no counter increments. Register writes still apply.
- R11: Counting happens only when the filter is 3, or when the filter equals `priv_mode` (0 supervisor, 1 hypervisor, 2 user).
- R12: A register write to a counter wins over an increment of that counter in the same cycle.
- R13: A logical counter whose control bit 22 is clear never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 64 | Event lines |
| priv_mode | input | 2 | Current privilege mode |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (a status read clears) |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench builds the unit with its default parameters: four physical counters, 64 event lines and a 5-bit register address. These defaults fix the spec bit positions that the bench's constants depend on. With them, the bench can walk one physical counter through both split and 32-bit modes. It can also preset counters one step below or at their 16-bit and 32-bit maximums, so that wrap, saturation and the status/interrupt path are reached in a few cycles. Each event line is driven by its own directed task, so edge, level, inverted and gated counting are each measured as exact counts.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int PM_NUM_PHYS = 4;
  localparam int PM_NUM_EVT  = 64;
  localparam int PM_ADDR_W   = 5;
  localparam int PM_DW       = 32;

  // global control bit positions
  localparam int GC_EN        = 31;
  localparam int GC_SAT       = 30;
  localparam int GC_SPLIT_TOP = 24;
  localparam int GC_FRZ       = 20;
  localparam int GC_PRIV_LO   = 18;
  localparam logic [31:0] GC_MASK = 32'hC1FC_0000;

  // counter control bit positions
  localparam int CC_SEL_TOP = 31;
  localparam int CC_INV     = 24;
  localparam int CC_CYC     = 23;
  localparam int CC_EN      = 22;
  localparam logic [31:0] CC_MASK = 32'hFDC0_0000;

  // word addresses
  localparam int A_GCTL = 0;
  localparam int A_STAT = 1;
  localparam int A_MASK = 2;
  localparam int A_CCTL = 8;
  localparam int A_CNT  = 16;

  typedef enum logic [1:0] {
    PRIV_SUPER = 2'd0,
    PRIV_HYPER = 2'd1,
    PRIV_USER  = 2'd2,
    PRIV_ALL   = 2'd3
  } priv_t;
endpackage

// File: rtl/perfmon_evt_sel.sv
module perfmon_evt_sel #(
  parameter int NUM_EVT = 64,
  parameter int SEL_W   = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [SEL_W-1:0]   sel,
  input  logic               invert,
  input  logic               cycles,
  input  logic               enable,
  output logic               hit
);
  logic sig, sig_prev_q;

  assign sig = evt_in[sel] ^ invert;

  // history always tracks the line so edge mode needs no warm-up after enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_prev_q <= 1'b0;
    else        sig_prev_q <= sig;
  end

  assign hit = enable & (cycles ? sig : (sig & ~sig_prev_q));
endmodule

// File: rtl/perfmon_phys_ctr.sv
module perfmon_phys_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         split,
  input  logic         sat,
  input  logic         inc_lo,
  input  logic         inc_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         ovf_lo,
  output logic         ovf_hi
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] FULL_MAX = {W{1'b1}};
  localparam logic [W-1:0] HALF_MAX = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [W-1:0] cnt_q, cnt_nxt, step_full, step_lo, step_hi;
  logic         of_full, of_lo, of_hi;

  // returns {overflow, next}
  function automatic logic [W:0] bump(input logic [W-1:0] v,
                                      input logic [W-1:0] maxv,
                                      input logic         s);
    logic [W-1:0] plus;
    plus = v + 1'b1;
    if (v == maxv) bump = {~s, (s ? v : {W{1'b0}})};
    else           bump = {s & (plus == maxv), plus};
  endfunction

  assign {of_full, step_full} = bump(cnt_q, FULL_MAX, sat);
  assign {of_lo, step_lo}     = bump({{HALF{1'b0}}, cnt_q[HALF-1:0]}, HALF_MAX, sat);
  assign {of_hi, step_hi}     = bump({{HALF{1'b0}}, cnt_q[W-1:HALF]}, HALF_MAX, sat);

  always_comb begin
    cnt_nxt = cnt_q;
    ovf_lo  = 1'b0;
    ovf_hi  = 1'b0;
    if (!split) begin
      if (wr_lo) cnt_nxt = wdata;
      else if (inc_lo) begin
        cnt_nxt = step_full;
        ovf_lo  = of_full;
      end
    end else begin
      if (wr_lo) cnt_nxt[HALF-1:0] = wdata[HALF-1:0];
      else if (inc_lo) begin
        cnt_nxt[HALF-1:0] = step_lo[HALF-1:0];
        ovf_lo            = of_lo;
      end
      if (wr_hi) cnt_nxt[W-1:HALF] = wdata[HALF-1:0];
      else if (inc_hi) begin
        cnt_nxt[W-1:HALF] = step_hi[HALF-1:0];
        ovf_hi            = of_hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign value = cnt_q;
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int NUM_PHYS = PM_NUM_PHYS,
  parameter int NUM_EVT  = PM_NUM_EVT,
  parameter int ADDR_W   = PM_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [1:0]         priv_mode,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam int NUM_LOG = 2 * NUM_PHYS;
  localparam int SEL_W   = $clog2(NUM_EVT);
  localparam int HALF    = PM_DW / 2;

  logic [31:0]            gctl_q;
  logic [31:0]            cctl_q [NUM_LOG];
  logic [NUM_LOG-1:0]     sts_q, mask_q, hit, ovf_log;
  logic [NUM_PHYS-1:0]    split;
  logic [31:0]            phys_val [NUM_PHYS];
  logic [31:0]            log_val  [NUM_LOG];
  logic [NUM_PHYS*32-1:0] phys_flat;
  logic                   count_ok, stat_rd;
  priv_t                  filter;

  assign filter   = priv_t'(gctl_q[GC_PRIV_LO +: 2]);
  assign count_ok = gctl_q[GC_EN] & ~gctl_q[GC_FRZ] &
                    ((filter == PRIV_ALL) | (filter == priv_t'(priv_mode)));
  assign stat_rd  = reg_rd_en && (reg_addr == ADDR_W'(A_STAT));

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q <= '0;
      mask_q <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == ADDR_W'(A_GCTL)) gctl_q <= reg_wdata & GC_MASK;
      if (reg_addr == ADDR_W'(A_MASK))
        for (int n = 0; n < NUM_LOG; n++) mask_q[n] <= reg_wdata[31-n];
    end
  end

  genvar gn, gp;
  generate
    for (gn = 0; gn < NUM_LOG; gn++) begin : g_log
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cctl_q[gn] <= '0;
        else if (reg_wr_en && reg_addr == ADDR_W'(A_CCTL + gn))
          cctl_q[gn] <= reg_wdata & CC_MASK;
      end

      perfmon_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .sel    (cctl_q[gn][CC_SEL_TOP -: SEL_W]),
        .invert (cctl_q[gn][CC_INV]),
        .cycles (cctl_q[gn][CC_CYC]),
        .enable (cctl_q[gn][CC_EN]),
        .hit    (hit[gn])
      );
    end

    for (gp = 0; gp < NUM_PHYS; gp++) begin : g_phys
      assign split[gp] = gctl_q[GC_SPLIT_TOP - gp];

      perfmon_phys_ctr #(.W(PM_DW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .split  (split[gp]),
        .sat    (gctl_q[GC_SAT]),
        .inc_lo (hit[gp] & count_ok),
        .inc_hi (hit[gp+NUM_PHYS] & count_ok),
        .wr_lo  (reg_wr_en && reg_addr == ADDR_W'(A_CNT + gp)),
        .wr_hi  (reg_wr_en && reg_addr == ADDR_W'(A_CNT + gp + NUM_PHYS)),
        .wdata  (reg_wdata),
        .value  (phys_val[gp]),
        .ovf_lo (ovf_log[gp]),
        .ovf_hi (ovf_log[gp+NUM_PHYS])
      );

      assign phys_flat[gp*32 +: 32] = phys_val[gp];
      assign log_val[gp] = split[gp] ? {{HALF{1'b0}}, phys_val[gp][HALF-1:0]}
                                     : phys_val[gp];
      assign log_val[gp+NUM_PHYS] = split[gp] ? {{HALF{1'b0}}, phys_val[gp][31:HALF]}
                                              : 32'd0;
    end
  endgenerate

  // sticky overflow status, cleared by reading it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts_q <= '0;
    else if (stat_rd) sts_q <= ovf_log;
    else              sts_q <= sts_q | ovf_log;
  end

  assign irq = |(sts_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_GCTL)) reg_rdata = gctl_q;
    if (reg_addr == ADDR_W'(A_STAT))
      for (int n = 0; n < NUM_LOG; n++) reg_rdata[31-n] = sts_q[n];
    if (reg_addr == ADDR_W'(A_MASK))
      for (int n = 0; n < NUM_LOG; n++) reg_rdata[31-n] = mask_q[n];
    for (int n = 0; n < NUM_LOG; n++) begin
      if (reg_addr == ADDR_W'(A_CCTL + n)) reg_rdata = cctl_q[n];
      if (reg_addr == ADDR_W'(A_CNT + n))  reg_rdata = log_val[n];
    end
  end
endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk #(
  parameter int NUM_PHYS = 4,
  parameter int ADDR_W   = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr_en,
  input logic                   reg_rd_en,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [31:0]            gctl_q,
  input logic [2*NUM_PHYS-1:0]  sts_q,
  input logic [2*NUM_PHYS-1:0]  mask_q,
  input logic                   irq,
  input logic [NUM_PHYS*32-1:0] phys_flat
);
  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl_q[20] && !reg_wr_en) |=> $stable(phys_flat));

  assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gctl_q[31] && !reg_wr_en) |=> $stable(phys_flat));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_en && reg_addr == ADDR_W'(1)) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q == '0) |-> !irq);

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PHYS; gp++) begin : g_sat
      assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_q[30] && !gctl_q[24-gp] && !reg_wr_en &&
         phys_flat[gp*32 +: 32] == 32'hFFFF_FFFF) |=> (phys_flat[gp*32 +: 32] == 32'hFFFF_FFFF));
    end
  endgenerate
endmodule

bind perfmon_unit perfmon_unit_chk #(.NUM_PHYS(NUM_PHYS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .gctl_q    (gctl_q),
  .sts_q     (sts_q),
  .mask_q    (mask_q),
  .irq       (irq),
  .phys_flat (phys_flat)
);

// File: tb/perfmon_unit_tb_top.sv
`timescale 1ns/1ps
module perfmon_unit_tb_top;
  localparam int CLK_NS = 20;
  localparam logic [31:0] G_EN  = 32'h8000_0000;
  localparam logic [31:0] G_SAT = 32'h4000_0000;
  localparam logic [31:0] G_FRZ = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic [1:0]  priv_mode = 2'd0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  perfmon_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .priv_mode(priv_mode),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] split_bit(int p);
    return 32'd1 << (24 - p);
  endfunction
  function automatic logic [31:0] priv_f(int m);
    return 32'(m) << 18;
  endfunction
  function automatic logic [31:0] cc(int sel, bit inv, bit cyc, bit en);
    return (32'(sel) << 26) | (32'(inv) << 24) | (32'(cyc) << 23) | (32'(en) << 22);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 5'(addr); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 5'(addr);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic rd_chk(string req, int addr, logic [31:0] exp);
    logic [31:0] v;
    rd(addr, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(int idx, int n);
    @(negedge clk);
    evt[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt[idx] = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 gctl", 0, 32'd0);
    rd_chk("R1 status", 1, 32'd0);
    rd_chk("R1 ctr0", 16, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
  endtask

  task automatic t_regmap();
    wr(0, 32'hFFFF_FFFF); rd_chk("R2 gctl bits", 0, 32'hC1FC_0000); wr(0, 0);
    wr(8, 32'hFFFF_FFFF); rd_chk("R2 cctl bits", 8, 32'hFDC0_0000); wr(8, 0);
    wr(2, 32'hFFFF_FFFF); rd_chk("R2 mask bits", 2, 32'hFF00_0000); wr(2, 0);
    wr(1, 32'hFFFF_FFFF); rd_chk("R2 status not writable", 1, 32'd0);
  endtask

  task automatic t_event();
    wr(0, G_EN);
    wr(8, cc(5, 0, 0, 1));
    wr(9, cc(5, 0, 0, 0));
    pulse(5, 3); pulse(5, 3);
    rd_chk("R3 edge count", 16, 32'd2);
    rd_chk("R13 disabled counter", 17, 32'd0);
    wr(8, 0); wr(9, 0);
  endtask

  task automatic t_cycle();
    wr(9, cc(7, 0, 1, 1));
    pulse(7, 5);
    rd_chk("R4 cycle count", 17, 32'd5);
    wr(9, 0);
  endtask

  task automatic t_polarity();
    @(negedge clk) evt[9] = 1'b1;
    wr(10, cc(9, 1, 0, 1));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) evt[9] = 1'b0;
      @(negedge clk) evt[9] = 1'b1;
    end
    rd_chk("R5 inverted edges", 18, 32'd3);
    wr(10, 0);
    @(negedge clk) evt[9] = 1'b0;
  endtask

  task automatic t_write_prio();
    wr(9, cc(7, 0, 1, 1));
    @(negedge clk);
    evt[7] = 1'b1; reg_wr_en = 1'b1; reg_addr = 5'd17; reg_wdata = 32'd100;
    @(negedge clk);
    evt[7] = 1'b0; reg_wr_en = 1'b0;
    rd_chk("R12 write beats increment", 17, 32'd100);
    wr(9, 0);
  endtask

  task automatic t_split();
    wr(0, G_EN | split_bit(3));
    wr(11, cc(11, 0, 0, 1));
    wr(15, cc(12, 0, 1, 1));
    wr(19, 32'h10); wr(23, 32'h20);
    pulse(11, 2); pulse(12, 4);
    rd_chk("R6 low half", 19, 32'h11);
    rd_chk("R6 high half", 23, 32'h24);
    wr(0, G_EN);
    rd_chk("R6 32-bit view", 19, 32'h0024_0011);
    rd_chk("R6 upper reads zero", 23, 32'd0);
    wr(23, 32'h55);
    rd_chk("R6 upper write ignored", 19, 32'h0024_0011);
    wr(11, 0); wr(15, 0);
  endtask

  task automatic t_wrap();
    wr(0, G_EN | split_bit(3));
    wr(11, cc(11, 0, 0, 1));
    wr(2, 32'h1000_0000);
    wr(19, 32'hFFFF);
    pulse(11, 1);
    rd_chk("R7 16-bit wrap", 19, 32'd0);
    rd_chk("R7 neighbour untouched", 23, 32'h24);
    chk("R9 irq raised", 32'(irq), 32'd1);
    rd_chk("R7 status bit 28", 1, 32'h1000_0000);
    rd_chk("R9 status cleared", 1, 32'd0);
    chk("R9 irq dropped", 32'(irq), 32'd0);
    wr(11, 0); wr(2, 0);
  endtask

  task automatic t_sat();
    wr(0, G_EN | G_SAT);
    wr(8, cc(5, 0, 0, 1));
    wr(16, 32'hFFFF_FFFE);
    pulse(5, 1);
    rd_chk("R8 reaches max", 16, 32'hFFFF_FFFF);
    rd_chk("R8 status on reaching", 1, 32'h8000_0000);
    pulse(5, 1); pulse(5, 1);
    rd_chk("R8 holds max", 16, 32'hFFFF_FFFF);
    rd_chk("R8 no second overflow", 1, 32'd0);
  endtask

  task automatic t_gate();
    wr(0, G_EN | G_FRZ);
    wr(16, 32'd7);
    pulse(5, 1);
    rd_chk("R10 freeze", 16, 32'd7);
    wr(0, 0);
    pulse(5, 1);
    rd_chk("R10 disabled", 16, 32'd7);
    wr(0, G_EN);
    pulse(5, 1);
    rd_chk("R10 resumes", 16, 32'd8);
  endtask

  task automatic t_priv();
    wr(0, G_EN | priv_f(2));
    priv_mode = 2'd0;
    pulse(5, 1);
    rd_chk("R11 mismatch", 16, 32'd8);
    priv_mode = 2'd2;
    pulse(5, 1);
    rd_chk("R11 match", 16, 32'd9);
    wr(0, G_EN | priv_f(3));
    priv_mode = 2'd1;
    pulse(5, 1);
    rd_chk("R11 all modes", 16, 32'd10);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_event();
    t_cycle();
    t_polarity();
    t_write_prio();
    t_split();
    t_wrap();
    t_sat();
    t_gate();
    t_priv();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule